// File: doc/BRIEF.md
# Indirect-Window PCS Register File

This block is the 16-bit configuration store of a serial-link PCS. Software reaches it through an 8 KiB memory window using aligned 16-bit accesses. One fixed slot in the window holds a selector word. Every other slot is routed to one of four register banks, chosen by the selector value: basic control, standard MII management, timing-sync, and an extended vendor bank. Only storage and decoding are modelled. A read returns what was last stored or loaded as a default. A write stores its data.

Each bank has its own default image, which a hardware reset loads. A software reset loads the same images. It is triggered by writing a word with its top bit set to the first register of the MII bank. That reload covers all four banks at once and leaves the selector word as it was. Read data is registered, so it lands one cycle after the read strobe.

Top module: `pcs_regwin`

## Requirements
- R1: After hardware reset the selector word is 0x0000, `bus_rdata` is 0x0000, and every bank register holds its default.
- R2: Byte offset 0x1FE of the window is the selector word. A write there stores all 16 data bits, and a read there returns the stored value.
- R3: At any other offset the selector picks the bank: 0x1E00 selects control, 0x1F00 selects MII, 0x1F07 selects timing-sync and 0x1F80 selects vendor. At most one bank is addressed at a time.
- R4: Inside a bank the register index is the byte offset shifted right by one. A write stores its data at that index of the selected bank only, and a later read there returns it.
- R5: An index at or beyond the bank depth (9 control, 16 MII, 17 timing-sync and 227 vendor, by default) reads as 0x0000. A write to such an index changes no register.
- R6: When the selector holds any value other than the four bank codes, a window read returns 0x0000 and a write changes no register.
- R7: A write to MII index 0 with data bit 15 set reloads every register in all four banks with its default, in the same cycle. The MII index 0 register then reads 0x1140, and the selector keeps its value.
- R8: Bit 15 written to MII index 0 is the only trigger of the reload. A MII index 0 write with bit 15 clear is stored as given, and bit 15 written to index 0 of any other bank is stored as plain data.
- R9: The default images are as follows. Control: index 4 = 0x699E, index 8 = 0x8000. MII: 0 = 0x1140, 1 = 0x0109, 2 = 0x699E, 3 = 0xCED0, 4 = 0x0020, 15 = 0xC000. Timing-sync: 8 = 0x0003, 9 = 0x0038, 11 = 0x0038, 13 = 0x0058, 15 = 0x0048. Vendor: 0 = 0x2400, 2 = 0x000A, 6 = 0x899C, 16 = 0x0010, 56 = 0x000A, 58 = 0x007F, 61 = 0x0001, 88 = 0x0100, 89 = 0x1100, 93 = 0x000E, 120 = 0x0100, 121 = 0x0032, 136 = 0x0001, 152 = 0x0019. Every other register defaults to 0x0000.
- R10: `bus_rdata` takes the addressed value at the clock edge where `bus_rd` is high and holds it until the next read. If a read and a write fall in the same cycle, the read returns the value from before the write.
- R11: Address bit 0 is ignored, so an odd byte address acts as the even address below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 13 | Byte address inside the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |

## Verification
A write takes effect at the rising edge where `bus_wr` is high. This holds for the software reload as well, which lands on that same edge. A read captures its value at the edge where `bus_rd` is high. The bench therefore drives each strobe for one cycle starting at a falling edge, and it samples `bus_rdata` at the next falling edge, half a cycle after the capture. The hold and same-cycle read/write checks sample over idle cycles that follow a read, so they can see whether the read data moved when it should not have.

// File: rtl/pcs_regwin_pkg.sv
package pcs_regwin_pkg;

  typedef enum logic [1:0] {
    BK_CTL  = 2'd0,
    BK_MII  = 2'd1,
    BK_SYNC = 2'd2,
    BK_VND  = 2'd3
  } bank_e;

  localparam int NUM_BANKS = 4;
  localparam int DATA_W    = 16;

  // Selector codes, one per bank
  function automatic logic [DATA_W-1:0] bank_code(input bank_e b);
    case (b)
      BK_CTL:  return 16'h1E00;
      BK_MII:  return 16'h1F00;
      BK_SYNC: return 16'h1F07;
      default: return 16'h1F80;
    endcase
  endfunction

  // Default image, addressed by register index (byte offset / 2)
  function automatic logic [DATA_W-1:0] bank_default(input bank_e b, input int unsigned idx);
    logic [DATA_W-1:0] v;
    v = '0;
    case (b)
      BK_CTL: begin
        case (idx)
          4:       v = 16'h699E;
          8:       v = 16'h8000;
          default: v = '0;
        endcase
      end
      BK_MII: begin
        case (idx)
          0:       v = 16'h1140;
          1:       v = 16'h0109;
          2:       v = 16'h699E;
          3:       v = 16'hCED0;
          4:       v = 16'h0020;
          15:      v = 16'hC000;
          default: v = '0;
        endcase
      end
      BK_SYNC: begin
        case (idx)
          8:       v = 16'h0003;
          9:       v = 16'h0038;
          11:      v = 16'h0038;
          13:      v = 16'h0058;
          15:      v = 16'h0048;
          default: v = '0;
        endcase
      end
      default: begin
        case (idx)
          0:       v = 16'h2400;
          2:       v = 16'h000A;
          6:       v = 16'h899C;
          16:      v = 16'h0010;
          56:      v = 16'h000A;
          58:      v = 16'h007F;
          61:      v = 16'h0001;
          88:      v = 16'h0100;
          89:      v = 16'h1100;
          93:      v = 16'h000E;
          120:     v = 16'h0100;
          121:     v = 16'h0032;
          136:     v = 16'h0001;
          152:     v = 16'h0019;
          default: v = '0;
        endcase
      end
    endcase
    return v;
  endfunction

endpackage

// File: rtl/pcs_win_decode.sv
module pcs_win_decode
  import pcs_regwin_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int SEL_OFFS = 'h1FE,
  localparam int IDX_W   = ADDR_W - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    sel_word,
  output logic                 is_sel,
  output logic [NUM_BANKS-1:0] bank_hit,
  output logic [IDX_W-1:0]     reg_idx
);

  localparam logic [IDX_W-1:0] SEL_IDX = IDX_W'(SEL_OFFS >> 1);

  // Bit 0 is dropped: only aligned halfword accesses exist
  assign reg_idx = addr[ADDR_W-1:1];
  assign is_sel  = (reg_idx == SEL_IDX);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_hit
    assign bank_hit[g] = !is_sel && (sel_word == bank_code(bank_e'(g)));
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_hit)); // R3

  AST_SEL_NO_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    is_sel |-> (bank_hit == '0)); // R2

endmodule

// File: rtl/pcs_bank.sv
module pcs_bank
  import pcs_regwin_pkg::*;
#(
  parameter bank_e BANK  = BK_CTL,
  parameter int    DEPTH = 9,
  parameter int    IDX_W = 12,
  localparam int   SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              reload,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_val
);

  logic [DATA_W-1:0] regs [DEPTH];
  logic              in_rng;
  logic [SLOT_W-1:0] slot;

  assign in_rng = (idx < IDX_W'(DEPTH));
  assign slot   = SLOT_W'(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= bank_default(BANK, i);
    end else if (reload) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= bank_default(BANK, i);
    end else if (wr_en && in_rng) begin
      regs[slot] <= wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (in_rng) rd_val = regs[slot];
  end

  AST_RELOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (regs[0] == bank_default(BANK, 0))); // R7

  AST_RELOAD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (regs[DEPTH-1] == bank_default(BANK, DEPTH-1))); // R7

endmodule

// File: rtl/pcs_regwin.sv
module pcs_regwin
  import pcs_regwin_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DEPTH_CTL  = 9,
  parameter int DEPTH_MII  = 16,
  parameter int DEPTH_SYNC = 17,
  parameter int DEPTH_VND  = 227
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [12:0]       bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata
);

  localparam int IDX_W = ADDR_W - 1;

  function automatic int depth_of(input int b);
    case (b)
      0:       return DEPTH_CTL;
      1:       return DEPTH_MII;
      2:       return DEPTH_SYNC;
      default: return DEPTH_VND;
    endcase
  endfunction

  logic [DATA_W-1:0]    sel_q;
  logic                 is_sel;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [IDX_W-1:0]     reg_idx;
  logic [DATA_W-1:0]    bank_rd [NUM_BANKS];
  logic [DATA_W-1:0]    rd_mux;
  logic                 sel_wr_evt;
  logic                 reload_evt;
  logic                 bad_sel;

  pcs_win_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (ADDR_W'(bus_addr)),
    .sel_word (sel_q),
    .is_sel   (is_sel),
    .bank_hit (bank_hit),
    .reg_idx  (reg_idx)
  );

  assign sel_wr_evt = bus_wr && is_sel;
  assign reload_evt = bus_wr && bank_hit[BK_MII] && (reg_idx == '0) && bus_wdata[15];
  assign bad_sel    = !is_sel && (bank_hit == '0);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    pcs_bank #(
      .BANK  (bank_e'(g)),
      .DEPTH (depth_of(g)),
      .IDX_W (IDX_W)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_wr && bank_hit[g]),
      .reload (reload_evt),
      .idx    (reg_idx),
      .wdata  (bus_wdata),
      .rd_val (bank_rd[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (is_sel) rd_mux = sel_q;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_hit[b]) rd_mux = rd_mux | bank_rd[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sel_q <= '0;
    else if (sel_wr_evt) sel_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_SEL_KEPT_ON_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> (sel_q == $past(sel_q))); // R7

  AST_BAD_SEL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bad_sel) |=> (bus_rdata == '0)); // R6

  AST_SEL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && is_sel) |=> (bus_rdata == $past(sel_q))); // R2

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R10

endmodule

// File: tb/sim_pcs_regwin.sv
`timescale 1ns/1ps
module sim_pcs_regwin;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [12:0] SEL = 13'h1FE;

  always #10 clk = ~clk;

  pcs_regwin u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic expect_at(input string req, input logic [12:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    check("R1 rdata after reset", bus_rdata, 16'h0000);
    expect_at("R1 selector after reset", SEL, 16'h0000);
    expect_at("R6 read with selector 0", 13'h000, 16'h0000);
  endtask

  task automatic t_selector();
    wr(SEL, 16'hABCD);
    expect_at("R2 selector readback", SEL, 16'hABCD);
    expect_at("R11 odd address hits selector", 13'h1FF, 16'hABCD);
  endtask

  task automatic t_defaults();
    wr(SEL, 16'h1E00);
    expect_at("R9 ctl idx4", 13'h008, 16'h699E);
    expect_at("R9 ctl idx8", 13'h010, 16'h8000);
    expect_at("R9 ctl idx0 zero", 13'h000, 16'h0000);
    wr(SEL, 16'h1F00);
    expect_at("R9 mii idx0", 13'h000, 16'h1140);
    expect_at("R9 mii idx3", 13'h006, 16'hCED0);
    expect_at("R9 mii idx15", 13'h01E, 16'hC000);
    wr(SEL, 16'h1F07);
    expect_at("R9 sync idx8", 13'h010, 16'h0003);
    expect_at("R9 sync idx13", 13'h01A, 16'h0058);
    expect_at("R9 sync idx15", 13'h01E, 16'h0048);
    wr(SEL, 16'h1F80);
    expect_at("R9 vnd idx0", 13'h000, 16'h2400);
    expect_at("R9 vnd idx58", 13'h074, 16'h007F);
    expect_at("R9 vnd idx152", 13'h130, 16'h0019);
    expect_at("R9 vnd idx89", 13'h0B2, 16'h1100);
  endtask

  task automatic t_store();
    wr(SEL, 16'h1E00); wr(13'h006, 16'h1111);
    wr(SEL, 16'h1F00); wr(13'h006, 16'h2222);
    wr(SEL, 16'h1F07); wr(13'h006, 16'h3333);
    wr(SEL, 16'h1F80); wr(13'h006, 16'h4444);
    wr(13'h1C4, 16'h5A5A);
    expect_at("R4 vnd idx3", 13'h006, 16'h4444);
    expect_at("R4 vnd last idx226", 13'h1C4, 16'h5A5A);
    wr(SEL, 16'h1E00);
    expect_at("R4 ctl idx3", 13'h006, 16'h1111);
    expect_at("R11 odd address ctl idx3", 13'h007, 16'h1111);
    wr(SEL, 16'h1F00);
    expect_at("R4 mii idx3", 13'h006, 16'h2222);
    wr(SEL, 16'h1F07);
    expect_at("R4 sync idx3", 13'h006, 16'h3333);
  endtask

  task automatic t_range();
    wr(SEL, 16'h1E00);
    wr(13'h012, 16'h5555);
    expect_at("R5 ctl idx9 reads zero", 13'h012, 16'h0000);
    expect_at("R5 ctl idx0 untouched", 13'h000, 16'h0000);
    expect_at("R5 ctl idx8 untouched", 13'h010, 16'h8000);
    wr(SEL, 16'h1F80);
    wr(13'h1C6, 16'h7777);
    expect_at("R5 vnd idx227 reads zero", 13'h1C6, 16'h0000);
    expect_at("R5 vnd idx226 untouched", 13'h1C4, 16'h5A5A);
  endtask

  task automatic t_invalid();
    wr(SEL, 16'h1F01);
    wr(13'h000, 16'h9999);
    wr(13'h006, 16'h9999);
    expect_at("R6 bad selector read", 13'h006, 16'h0000);
    wr(SEL, 16'h1F00);
    expect_at("R6 mii idx0 untouched", 13'h000, 16'h1140);
    expect_at("R6 mii idx3 untouched", 13'h006, 16'h2222);
  endtask

  task automatic t_nosoft();
    wr(SEL, 16'h1F00);
    wr(13'h000, 16'h0AB0);
    expect_at("R8 mii idx0 plain store", 13'h000, 16'h0AB0);
    wr(SEL, 16'h1E00);
    wr(13'h000, 16'h8001);
    expect_at("R8 ctl idx0 bit15 stored", 13'h000, 16'h8001);
    wr(SEL, 16'h1F00);
    expect_at("R8 no reload from ctl bank", 13'h000, 16'h0AB0);
  endtask

  task automatic t_softrst();
    wr(SEL, 16'h1F80); wr(13'h000, 16'hFFFF);
    wr(SEL, 16'h1F00);
    wr(13'h000, 16'h8123);
    expect_at("R7 mii ctl after reload", 13'h000, 16'h1140);
    expect_at("R7 selector kept", SEL, 16'h1F00);
    expect_at("R7 mii idx3 restored", 13'h006, 16'hCED0);
    wr(SEL, 16'h1E00);
    expect_at("R7 ctl idx0 restored", 13'h000, 16'h0000);
    expect_at("R7 ctl idx3 restored", 13'h006, 16'h0000);
    wr(SEL, 16'h1F07);
    expect_at("R7 sync idx3 restored", 13'h006, 16'h0000);
    wr(SEL, 16'h1F80);
    expect_at("R7 vnd idx0 restored", 13'h000, 16'h2400);
    expect_at("R7 vnd idx226 restored", 13'h1C4, 16'h0000);
  endtask

  task automatic t_timing();
    logic [15:0] v;
    wr(SEL, 16'h1F00);
    wr(13'h00A, 16'h1234);
    rd(13'h00A, v);
    check("R10 read one cycle later", v, 16'h1234);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 rdata holds when idle", bus_rdata, 16'h1234);
    end
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 13'h00A; bus_wdata = 16'h4321;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    check("R10 same-cycle read sees old value", bus_rdata, 16'h1234);
    expect_at("R10 write from same cycle stored", 13'h00A, 16'h4321);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_selector();
    t_defaults();
    t_store();
    t_range();
    t_invalid();
    t_nosoft();
    t_softrst();
    t_timing();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule